// File: doc/BRIEF.md
# Dual-Issue Pair Dispatcher

This block sits between the decode stage and two ALU lanes of an in-order front end that handles two instructions per cycle. Each cycle it looks at an ordered pair of decoded instructions, older first. It sends both to the lanes together when the younger one does not depend on the older one. Otherwise it sends only the older one. Dependences on instructions issued in earlier cycles are left to the forwarding network and are not examined here.

A younger instruction that cannot go out with its partner is not thrown away. It is kept in a one-entry holding register and becomes the older member of the next pair. While that register is occupied, the fetch buffer is told to supply just one new instruction. The second input slot is then ignored, so no issue slot is lost to the split.

Both lanes share one register bank and one data cache. A parameter states whether the cache has one or two ports.

Top module: `disp_pair`

## Requirements
- R1: An instruction word packs, from the least significant bit upward: destination register, first source, second source, a write-enable bit, a memory-access bit, then a tag. With the defaults these sit at [4:0], [9:5], [14:10], [15], [16] and [24:17]. Lane 0 always carries the older issued instruction, and a lone issued instruction always goes to lane 0. Issue-mask bit 0 marks lane 0 and bit 1 marks lane 1, so the mask is never 2'b10.
- R2: When the older instruction writes a register that either source of the younger one names, only the older instruction issues (mask 2'b01).
- R3: When both instructions write the same destination register, only the older instruction issues.
- R4: With a single data-cache port (DPORTS=1, the default), two memory-access instructions in one pair force single issue. A pair with one memory access and no other conflict issues in full.
- R5: When neither R2, R3 nor R4 applies, both valid instructions issue in the same cycle (mask 2'b11).
- R6: A younger instruction left out by R2 to R4 is held. In the next cycle it is the older member, paired with the instruction on input slot 0. The held instruction cannot be displaced, so it issues in lane 0 that next cycle.
- R7: While an instruction is held, the fetch_one output is 1 and input slot 1 is ignored. Otherwise fetch_one is 0.
- R8: An invalid slot never issues and never blocks the other slot. A lone valid younger instruction issues in lane 0. With no valid instruction the mask is 2'b00.
- R9: The mask and the lane words appear on the clock edge after the inputs that produced them.
- R10: A synchronous active-high reset clears the mask and fetch_one and discards any held instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in0_vld | input | 1 | Input slot 0 holds a valid instruction |
| in0_ins | input | INS_W (25) | Input slot 0 instruction word, the older of the two slots |
| in1_vld | input | 1 | Input slot 1 holds a valid instruction |
| in1_ins | input | INS_W (25) | Input slot 1 instruction word, the younger slot |
| iss_mask | output | 2 | Registered issue mask, one bit per lane |
| lane0_ins | output | INS_W (25) | Registered instruction word for lane 0 |
| lane1_ins | output | INS_W (25) | Registered instruction word for lane 1 |
| fetch_one | output | 1 | Request for only one new instruction (slot 0) this cycle |

## Verification
The only internal state is the holding register, and it shows at the ports within one cycle. A lost held instruction shows as a missing tag in lane 0 on the cycle after a split. A stale one shows as a duplicated tag, or as fetch_one still high after an independent pair. A wrong hazard decision shows on the very next edge, as a mask of 2'b11 on a dependent pair or 2'b01 on an independent one. The bench therefore runs dependent and reordered instruction streams back to back and compares every mask and lane tag on each edge, including chains where a held instruction is split again.

// File: rtl/disp_pkg.sv
package disp_pkg;
  // Number of source operands examined per instruction.
  localparam int NSRC = 2;

  // Issue decision for one ordered pair.
  typedef enum logic [1:0] {
    PICK_NONE = 2'd0,
    PICK_OLD  = 2'd1,
    PICK_YNG  = 2'd2,
    PICK_BOTH = 2'd3
  } pick_e;
endpackage

// File: rtl/disp_hazard.sv
// Intra-pair conflict detection: read-after-write, write-after-write and
// data-cache port contention between the older and younger instruction.
module disp_hazard #(
  parameter int REG_W  = 5,
  parameter int DPORTS = 1
) (
  input  logic [REG_W-1:0]                   o_dst,
  input  logic                               o_wr,
  input  logic                               o_mem,
  input  logic [disp_pkg::NSRC-1:0][REG_W-1:0] y_src,
  input  logic [REG_W-1:0]                   y_dst,
  input  logic                               y_wr,
  input  logic                               y_mem,
  output logic                               raw,
  output logic                               waw,
  output logic                               mem_clash
);
  logic [disp_pkg::NSRC-1:0] src_hit;

  for (genvar s = 0; s < disp_pkg::NSRC; s++) begin : g_src
    assign src_hit[s] = o_wr && (y_src[s] == o_dst);
  end

  assign raw = |src_hit;
  assign waw = o_wr && y_wr && (o_dst == y_dst);

  if (DPORTS < 2) begin : g_one_port
    assign mem_clash = o_mem && y_mem;
  end else begin : g_two_port
    assign mem_clash = 1'b0;
  end
endmodule

// File: rtl/disp_hold.sv
// One-entry holding register for a younger instruction that lost its slot.
module disp_hold #(
  parameter int INS_W = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [INS_W-1:0] din,
  output logic             vld,
  output logic [INS_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) vld <= 1'b0;
    else     vld <= load;
  end

  always_ff @(posedge clk) begin
    if (load) q <= din;
  end
endmodule

// File: rtl/disp_lane_reg.sv
// Output register for one issue lane.
module disp_lane_reg #(
  parameter int INS_W = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld_in,
  input  logic [INS_W-1:0] din,
  output logic             vld_q,
  output logic [INS_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) vld_q <= 1'b0;
    else     vld_q <= vld_in;
  end

  always_ff @(posedge clk) begin
    q <= din;
  end
endmodule

// File: rtl/disp_pair.sv
// Dual-issue pair dispatcher: forms the ordered pair, decides single or
// paired issue, registers the lanes and keeps a split younger instruction.
module disp_pair #(
  parameter  int NREG   = 32,
  parameter  int TAG_W  = 8,
  parameter  int DPORTS = 1,
  localparam int REG_W  = $clog2(NREG),
  localparam int INS_W  = 3 * REG_W + 2 + TAG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in0_vld,
  input  logic [INS_W-1:0] in0_ins,
  input  logic             in1_vld,
  input  logic [INS_W-1:0] in1_ins,
  output logic [1:0]       iss_mask,
  output logic [INS_W-1:0] lane0_ins,
  output logic [INS_W-1:0] lane1_ins,
  output logic             fetch_one
);
  import disp_pkg::*;

  localparam int F_DST = 0;
  localparam int F_S0  = REG_W;
  localparam int F_S1  = 2 * REG_W;
  localparam int F_WR  = 3 * REG_W;
  localparam int F_MEM = 3 * REG_W + 1;
  localparam int NLANE = 2;

  // Held younger instruction from the previous cycle.
  logic             hold_vld;
  logic [INS_W-1:0] hold_ins;

  // Ordered pair for this cycle.
  logic             old_vld, yng_vld;
  logic [INS_W-1:0] old_ins, yng_ins;

  always_comb begin
    if (hold_vld) begin
      old_vld = 1'b1;
      old_ins = hold_ins;
      yng_vld = in0_vld;
      yng_ins = in0_ins;
    end else begin
      old_vld = in0_vld;
      old_ins = in0_ins;
      yng_vld = in1_vld;
      yng_ins = in1_ins;
    end
  end

  // Field extraction for the hazard check.
  logic [NSRC-1:0][REG_W-1:0] yng_src;
  assign yng_src[0] = yng_ins[F_S0 +: REG_W];
  assign yng_src[1] = yng_ins[F_S1 +: REG_W];

  logic raw, waw, mem_clash, conflict;

  disp_hazard #(
    .REG_W  (REG_W),
    .DPORTS (DPORTS)
  ) u_haz (
    .o_dst     (old_ins[F_DST +: REG_W]),
    .o_wr      (old_ins[F_WR]),
    .o_mem     (old_ins[F_MEM]),
    .y_src     (yng_src),
    .y_dst     (yng_ins[F_DST +: REG_W]),
    .y_wr      (yng_ins[F_WR]),
    .y_mem     (yng_ins[F_MEM]),
    .raw       (raw),
    .waw       (waw),
    .mem_clash (mem_clash)
  );

  assign conflict = raw || waw || mem_clash;

  // Issue decision.
  pick_e pick;

  always_comb begin
    unique case ({old_vld, yng_vld})
      2'b10:   pick = PICK_OLD;
      2'b01:   pick = PICK_YNG;
      2'b11:   pick = conflict ? PICK_OLD : PICK_BOTH;
      default: pick = PICK_NONE;
    endcase
  end

  logic [NLANE-1:0]            lane_v_d, lane_v_q;
  logic [NLANE-1:0][INS_W-1:0] lane_d, lane_q;

  always_comb begin
    lane_v_d[0] = (pick != PICK_NONE);
    lane_d[0]   = (pick == PICK_YNG) ? yng_ins : old_ins;
    lane_v_d[1] = (pick == PICK_BOTH);
    lane_d[1]   = yng_ins;
  end

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    disp_lane_reg #(
      .INS_W (INS_W)
    ) u_lane (
      .clk    (clk),
      .rst    (rst),
      .vld_in (lane_v_d[l]),
      .din    (lane_d[l]),
      .vld_q  (lane_v_q[l]),
      .q      (lane_q[l])
    );
  end

  // A split pair keeps its younger member.
  logic hold_load;
  assign hold_load = (pick == PICK_OLD) && yng_vld;

  disp_hold #(
    .INS_W (INS_W)
  ) u_hold (
    .clk  (clk),
    .rst  (rst),
    .load (hold_load),
    .din  (yng_ins),
    .vld  (hold_vld),
    .q    (hold_ins)
  );

  assign iss_mask  = lane_v_q;
  assign lane0_ins = lane_q[0];
  assign lane1_ins = lane_q[1];
  assign fetch_one = hold_vld;
endmodule

// File: rtl/disp_pair_chk.sv
// Port-level properties of the dispatcher, attached by bind.
module disp_pair_chk #(
  parameter int REG_W  = 5,
  parameter int TAG_W  = 8,
  parameter int DPORTS = 1,
  parameter int INS_W  = 3 * REG_W + 2 + TAG_W
) (
  input logic             clk,
  input logic             rst,
  input logic             in0_vld,
  input logic             in1_vld,
  input logic [1:0]       iss_mask,
  input logic [INS_W-1:0] lane0_ins,
  input logic [INS_W-1:0] lane1_ins,
  input logic             fetch_one
);
  localparam int F_S0  = REG_W;
  localparam int F_S1  = 2 * REG_W;
  localparam int F_WR  = 3 * REG_W;
  localparam int F_MEM = 3 * REG_W + 1;

  logic [REG_W-1:0] d0, d1, s10, s11;
  assign d0  = lane0_ins[REG_W-1:0];
  assign d1  = lane1_ins[REG_W-1:0];
  assign s10 = lane1_ins[F_S0 +: REG_W];
  assign s11 = lane1_ins[F_S1 +: REG_W];

  // R1: lane 1 never issues without lane 0
  a_r1_lane_order: assert property (@(posedge clk) disable iff (rst)
    iss_mask != 2'b10);

  // R2: a paired issue never carries a read-after-write dependence
  a_r2_no_raw_pair: assert property (@(posedge clk) disable iff (rst)
    (iss_mask == 2'b11 && lane0_ins[F_WR]) |-> (s10 != d0 && s11 != d0));

  // R3: a paired issue never has two writers of one register
  a_r3_no_waw_pair: assert property (@(posedge clk) disable iff (rst)
    (iss_mask == 2'b11 && lane0_ins[F_WR] && lane1_ins[F_WR]) |-> (d0 != d1));

  // R4: one cache port means at most one memory access per issued pair
  a_r4_mem_port: assert property (@(posedge clk) disable iff (rst)
    (DPORTS < 2 && iss_mask == 2'b11) |-> !(lane0_ins[F_MEM] && lane1_ins[F_MEM]));

  // R7: a held instruction only exists after a single issue
  a_r7_hold_single: assert property (@(posedge clk) disable iff (rst)
    fetch_one |-> iss_mask == 2'b01);

  // R6: a held instruction issues on the following edge
  a_r6_hold_drains: assert property (@(posedge clk) disable iff (rst)
    fetch_one |=> iss_mask[0]);

  // R8: nothing valid in, nothing issued
  a_r8_idle: assert property (@(posedge clk) disable iff (rst)
    (!in0_vld && !in1_vld && !fetch_one) |=> iss_mask == 2'b00);

  // R9: a valid slot 0 instruction issues on the next edge
  a_r9_next_edge: assert property (@(posedge clk) disable iff (rst)
    in0_vld |=> iss_mask[0]);

  // R10: reset clears the mask and the hold request
  a_r10_reset: assert property (@(posedge clk)
    rst |=> (iss_mask == 2'b00 && !fetch_one));
endmodule

bind disp_pair disp_pair_chk #(
  .REG_W  (REG_W),
  .TAG_W  (TAG_W),
  .DPORTS (DPORTS),
  .INS_W  (INS_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in0_vld   (in0_vld),
  .in1_vld   (in1_vld),
  .iss_mask  (iss_mask),
  .lane0_ins (lane0_ins),
  .lane1_ins (lane1_ins),
  .fetch_one (fetch_one)
);

// File: tb/sim_disp_pair.sv
module sim_disp_pair;
  localparam int CLK_PERIOD = 10;
  localparam int REG_W = 5;
  localparam int TAG_W = 8;
  localparam int INS_W = 3 * REG_W + 2 + TAG_W;
  localparam int ROW_W = 1 + INS_W + 1 + INS_W + 2 + 1 + 2 * TAG_W;
  localparam int NVEC  = 16;

  // Build an instruction word per the R1 layout.
  function automatic logic [INS_W-1:0] mk(input int tag, input int dst,
      input int s0, input int s1, input int wr, input int mem);
    logic [INS_W-1:0] w;
    w = '0;
    w[4:0]   = dst[4:0];
    w[9:5]   = s0[4:0];
    w[14:10] = s1[4:0];
    w[15]    = wr[0];
    w[16]    = mem[0];
    w[24:17] = tag[7:0];
    return w;
  endfunction

  localparam logic [INS_W-1:0] JNK = mk(99, 31, 31, 31, 1, 1);
  localparam logic [INS_W-1:0] NUL = '0;

  // Row: {v0, i0, v1, i1, exp_mask, exp_fetch_one, exp_tag0, exp_tag1}
  localparam logic [ROW_W-1:0] VEC [NVEC] = '{
    // R2: ADD r1 ; MUL reads r1 -> split
    {1'b1, mk(1,1,1,0,1,0), 1'b1, mk(2,2,1,1,1,0), 2'b01, 1'b1, 8'd1, 8'd0},
    // R6 R7: held MUL pairs with next ADD, slot 1 junk ignored
    {1'b1, mk(3,3,4,5,1,0), 1'b1, JNK,             2'b11, 1'b0, 8'd2, 8'd3},
    // R8: lone older, younger invalid
    {1'b1, mk(4,6,3,3,1,0), 1'b0, NUL,             2'b01, 1'b0, 8'd4, 8'd0},
    // R5: reordered ADD,ADD
    {1'b1, mk(5,1,1,0,1,0), 1'b1, mk(6,3,4,5,1,0), 2'b11, 1'b0, 8'd5, 8'd6},
    // R5: reordered MUL,MUL
    {1'b1, mk(7,2,1,1,1,0), 1'b1, mk(8,6,3,3,1,0), 2'b11, 1'b0, 8'd7, 8'd8},
    // R3: both write r7
    {1'b1, mk(10,7,1,2,1,0), 1'b1, mk(11,7,3,4,1,0), 2'b01, 1'b1, 8'd10, 8'd0},
    // R6: held 11 then slot 0 reads r7 -> split again
    {1'b1, mk(12,8,7,7,1,0), 1'b1, JNK,             2'b01, 1'b1, 8'd11, 8'd0},
    // R6: held 12 pairs with 13
    {1'b1, mk(13,9,1,1,1,0), 1'b1, JNK,             2'b11, 1'b0, 8'd12, 8'd13},
    // R4: load and store in one pair
    {1'b1, mk(14,10,1,2,1,1), 1'b1, mk(15,0,3,4,0,1), 2'b01, 1'b1, 8'd14, 8'd0},
    // R6 R8: held store issues alone, slot 0 invalid
    {1'b0, NUL,             1'b1, JNK,             2'b01, 1'b0, 8'd15, 8'd0},
    // R2: older writes nothing -> no dependence
    {1'b1, mk(16,5,1,1,0,0), 1'b1, mk(17,6,5,5,1,0), 2'b11, 1'b0, 8'd16, 8'd17},
    // R8: invalid older does not block younger, younger in lane 0
    {1'b0, NUL,             1'b1, mk(18,1,1,1,1,0), 2'b01, 1'b0, 8'd18, 8'd0},
    // R8: nothing valid
    {1'b0, NUL,             1'b0, NUL,             2'b00, 1'b0, 8'd0, 8'd0},
    // R2: dependence through second source only
    {1'b1, mk(19,4,0,0,1,0), 1'b1, mk(20,5,0,4,1,0), 2'b01, 1'b1, 8'd19, 8'd0},
    // R6: held drains, slot 1 junk ignored
    {1'b0, NUL,             1'b1, JNK,             2'b01, 1'b0, 8'd20, 8'd0},
    // R4: one memory access only -> full pair
    {1'b1, mk(21,1,2,3,1,1), 1'b1, mk(22,4,5,6,1,0), 2'b11, 1'b0, 8'd21, 8'd22}
  };

  logic             clk = 1'b0;
  logic             rst;
  logic             in0_vld, in1_vld;
  logic [INS_W-1:0] in0_ins, in1_ins;
  logic [1:0]       iss_mask;
  logic [INS_W-1:0] lane0_ins, lane1_ins;
  logic             fetch_one;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  disp_pair u0 (
    .clk       (clk),
    .rst       (rst),
    .in0_vld   (in0_vld),
    .in0_ins   (in0_ins),
    .in1_vld   (in1_vld),
    .in1_ins   (in1_ins),
    .iss_mask  (iss_mask),
    .lane0_ins (lane0_ins),
    .lane1_ins (lane1_ins),
    .fetch_one (fetch_one)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic v0, input logic [INS_W-1:0] i0,
                       input logic v1, input logic [INS_W-1:0] i1);
    in0_vld = v0; in0_ins = i0; in1_vld = v1; in1_ins = i1;
  endtask

  initial begin
    rst = 1'b1;
    drive(1'b0, NUL, 1'b0, NUL);
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset mask", int'(iss_mask), 0);
    chk("R10 reset fetch_one", int'(fetch_one), 0);
    @(negedge clk);
    rst = 1'b0;

    // Table walk: R1..R9
    for (int i = 0; i < NVEC; i++) begin
      logic [ROW_W-1:0] r;
      r = VEC[i];
      @(negedge clk);
      drive(r[ROW_W-1], r[ROW_W-2 -: INS_W], r[ROW_W-2-INS_W],
            r[ROW_W-3-INS_W -: INS_W]);
      @(posedge clk);
      #1;
      chk($sformatf("R9 R1 row %0d mask", i), int'(iss_mask), int'(r[18:17]));
      chk($sformatf("R7 row %0d fetch_one", i), int'(fetch_one), int'(r[16]));
      if (r[17]) chk($sformatf("R6 R1 row %0d lane0 tag", i),
                     int'(lane0_ins[24:17]), int'(r[15:8]));
      if (r[18]) chk($sformatf("R5 R1 row %0d lane1 tag", i),
                     int'(lane1_ins[24:17]), int'(r[7:0]));
    end

    // R10: reset discards a held instruction
    @(negedge clk);
    drive(1'b1, mk(40,7,1,2,1,0), 1'b1, mk(41,7,3,4,1,0));
    @(posedge clk); #1;
    chk("R3 split before reset", int'(fetch_one), 1);
    @(negedge clk);
    rst = 1'b1;
    drive(1'b0, NUL, 1'b0, NUL);
    @(posedge clk); #1;
    chk("R10 mid-hold mask", int'(iss_mask), 0);
    chk("R10 mid-hold fetch_one", int'(fetch_one), 0);
    @(negedge clk);
    rst = 1'b0;
    drive(1'b1, mk(30,1,2,3,1,0), 1'b1, mk(31,2,4,5,1,0));
    @(posedge clk); #1;
    chk("R10 after reset mask", int'(iss_mask), 3);
    chk("R10 after reset lane0 tag", int'(lane0_ins[24:17]), 30);
    chk("R10 after reset lane1 tag", int'(lane1_ins[24:17]), 31);

    // R8: idle input after a pair gives an empty mask
    @(negedge clk);
    drive(1'b0, NUL, 1'b0, NUL);
    @(posedge clk); #1;
    chk("R8 idle mask", int'(iss_mask), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule